// File: doc/BRIEF.md
# Composite Sync Type Detector

This block watches one digital composite sync input, already sampled into the reference clock domain, and decides three things: whether the input is alive, which style of composite sync it carries, and where its vertical interval lies. It learns the line period from successive rising edges. It then judges every later pulse against that period. A short high pulse is a line sync. A high pulse wider than a programmable fraction of the period means the polarity has flipped for the vertical interval (XOR style). A gap with no edges at all for more than two line periods means the pulses have stopped for the vertical interval (OR/AND style).

A free-running millisecond tick drives an activity window of a fixed number of ticks (80 by default). At the end of each window the block updates its activity flag and raises a one-cycle status strobe. Controlling software can then read the type code and the extracted vertical sync without any external sync separator.

Top module: `csync_type_detect`

## Requirements
- R1: While reset is asserted and until the first window ends, `sync_active`, `sync_type`, `vsync_out` and `status_valid` are all 0.
- R2: `status_valid` is a single-cycle strobe that fires once per `WINDOW_TICKS` ticks of `tick_ms`. `sync_active` changes only in the cycle the strobe is high. It becomes 1 when at least one edge of `csync_in` arrived during the window just closed.
- R3: A window that closes with no edge on `csync_in` clears `sync_active` and `vsync_out`. It forgets the learned line period and the type, so `sync_type` reads 2'b00.
- R4: `sync_type` encoding: 2'b00 no sync (inactive), 2'b01 OR/AND style, 2'b10 XOR style, 2'b11 active but no vertical interval recognised yet.
- R5: The line period is the rising-to-rising distance in clocks and is valid from the second rising edge onward. A high pulse whose width in clocks is greater than the period shifted right by `cfg_shift` (0 to 3) is wide and sets the type to XOR style. A pulse not greater than that is narrow.
- R6: Once a period is valid, if no edge occurs for twice the period, the type becomes OR/AND style. The pulse that ends such a gap is not judged wide or narrow, and the period that spans the gap is not learned.
- R7: `vsync_out` rises after a wide pulse or an edge-free gap and falls after the next narrow pulse.
- R8: The type follows the most recent vertical interval, so an input that switches from OR/AND style to XOR style without going idle is reported as XOR style.
- R9: The line pulse is the high level of `csync_in`. For OR/AND style the vertical interval holds the input at one level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_ms | input | 1 | One-cycle pulse per millisecond, synchronous to `clk` |
| csync_in | input | 1 | Digital composite sync, high level is the line pulse |
| cfg_shift | input | 2 | Wide-pulse threshold: period >> cfg_shift |
| sync_active | output | 1 | Edges seen in the last closed window |
| sync_type | output | 2 | Composite sync style code |
| vsync_out | output | 1 | Extracted vertical sync indication |
| status_valid | output | 1 | One-cycle strobe at each window end |

## Verification
The detector is driven with plain line pulses that have no vertical interval, with frames whose vertical interval holds the input high, and with frames whose vertical interval inverts every pulse. These three patterns separate the undetermined, OR/AND and XOR codes. The inverted frames are repeated with a zero threshold shift, so that the wide pulses no longer exceed the threshold; this shows that the programmable fraction, not the raw width, drives the decision. Every pattern is followed by a silent stretch to show that the status falls back to none. A directed switch from one style to the other, plus randomly chosen line periods, pulse widths and shifts, checks that the type and the vertical sync track the timing rather than fixed numbers.

// File: rtl/csd_pkg.sv
package csd_pkg;
  typedef enum logic [1:0] {
    CS_NONE  = 2'b00,
    CS_ORAND = 2'b01,
    CS_XOR   = 2'b10,
    CS_UNDET = 2'b11
  } cs_kind_t;
endpackage

// File: rtl/csd_sync.sv
// Flop chain used both for the input sampler and for the reset release.
module csd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/csd_meas.sv
// Learns the line period and classifies each pulse or edge-free gap.
module csd_meas #(
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       sig,
  input  logic [1:0] cfg_shift,
  output logic       edge_ev,
  output logic       wide_ev,
  output logic       narrow_ev,
  output logic       stall_ev
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             prev_q;
  logic [CNT_W-1:0] per_cnt_q, per_cnt_d;
  logic [CNT_W-1:0] wid_cnt_q, wid_cnt_d;
  logic [CNT_W-1:0] gap_cnt_q, gap_cnt_d;
  logic [CNT_W-1:0] period_q, period_d;
  logic             seen_rise_q, seen_rise_d;
  logic             per_ok_q, per_ok_d;
  logic             stalled_q, stalled_d;
  logic             edge_d, wide_d, narrow_d, stall_d;
  logic             rise, fall, judge, stall_hit;
  logic [CNT_W-1:0] thr;

  function automatic logic [CNT_W-1:0] inc_sat(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  assign rise = sig & ~prev_q;
  assign fall = ~sig & prev_q;
  assign thr  = period_q >> cfg_shift;

  always_comb begin
    per_cnt_d   = rise ? {{(CNT_W-1){1'b0}}, 1'b1} : inc_sat(per_cnt_q);
    wid_cnt_d   = rise ? {{(CNT_W-1){1'b0}}, 1'b1} : (sig ? inc_sat(wid_cnt_q) : wid_cnt_q);
    gap_cnt_d   = (rise | fall) ? '0 : inc_sat(gap_cnt_q);
    seen_rise_d = seen_rise_q | rise;
    period_d    = period_q;
    per_ok_d    = per_ok_q;
    if (rise && seen_rise_q && !stalled_q) begin
      period_d = per_cnt_q;
      per_ok_d = 1'b1;
    end
    stall_hit = per_ok_q && !stalled_q && !(rise | fall) &&
                ({1'b0, gap_cnt_q} == {period_q, 1'b0});
    stalled_d = rise ? 1'b0 : (stalled_q | stall_hit);
    judge     = fall && per_ok_q && !stalled_q;
    wide_d    = judge && (wid_cnt_q > thr);
    narrow_d  = judge && !(wid_cnt_q > thr);
    stall_d   = stall_hit;
    edge_d    = rise | fall;
    if (clr) begin
      per_cnt_d   = '0;
      wid_cnt_d   = '0;
      gap_cnt_d   = '0;
      period_d    = '0;
      seen_rise_d = 1'b0;
      per_ok_d    = 1'b0;
      stalled_d   = 1'b0;
      wide_d      = 1'b0;
      narrow_d    = 1'b0;
      stall_d     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q      <= 1'b0;
      per_cnt_q   <= '0;
      wid_cnt_q   <= '0;
      gap_cnt_q   <= '0;
      period_q    <= '0;
      seen_rise_q <= 1'b0;
      per_ok_q    <= 1'b0;
      stalled_q   <= 1'b0;
      edge_ev     <= 1'b0;
      wide_ev     <= 1'b0;
      narrow_ev   <= 1'b0;
      stall_ev    <= 1'b0;
    end else begin
      prev_q      <= sig;
      per_cnt_q   <= per_cnt_d;
      wid_cnt_q   <= wid_cnt_d;
      gap_cnt_q   <= gap_cnt_d;
      period_q    <= period_d;
      seen_rise_q <= seen_rise_d;
      per_ok_q    <= per_ok_d;
      stalled_q   <= stalled_d;
      edge_ev     <= edge_d;
      wide_ev     <= wide_d;
      narrow_ev   <= narrow_d;
      stall_ev    <= stall_d;
    end
  end

  AST_PERIOD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    per_ok_q |-> (period_q != '0)); // R5
  AST_STALL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    stall_ev |=> !stall_ev); // R6
  AST_JUDGED_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_ev || narrow_ev) |-> (edge_ev && !prev_q)); // R5
endmodule

// File: rtl/csd_class.sv
// Activity window, type state and vertical sync extraction.
module csd_class
  import csd_pkg::*;
#(
  parameter int WINDOW_TICKS = 80
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     edge_ev,
  input  logic     wide_ev,
  input  logic     narrow_ev,
  input  logic     stall_ev,
  output logic     flush,
  output logic     active,
  output cs_kind_t kind,
  output logic     vsync,
  output logic     valid
);
  localparam int WIN_W = (WINDOW_TICKS > 2) ? $clog2(WINDOW_TICKS) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_TICKS - 1);

  logic [WIN_W-1:0] win_cnt_q, win_cnt_d;
  logic             seen_q, seen_d;
  logic             active_d, vsync_d, valid_d;
  cs_kind_t         kind_d;
  logic             win_end, any_edge;

  assign win_end  = tick && (win_cnt_q == WIN_LAST);
  assign any_edge = seen_q | edge_ev;
  assign flush    = win_end && !any_edge;

  always_comb begin
    win_cnt_d = win_cnt_q;
    if (tick) win_cnt_d = win_end ? '0 : win_cnt_q + 1'b1;
    seen_d   = win_end ? 1'b0 : any_edge;
    active_d = active;
    kind_d   = kind;
    vsync_d  = vsync;
    valid_d  = 1'b0;
    if (stall_ev) begin
      kind_d  = CS_ORAND;
      vsync_d = 1'b1;
    end else if (wide_ev) begin
      kind_d  = CS_XOR;
      vsync_d = 1'b1;
    end else if (narrow_ev) begin
      vsync_d = 1'b0;
    end
    if (win_end) begin
      active_d = any_edge;
      valid_d  = 1'b1;
      if (!any_edge) begin
        kind_d  = CS_UNDET;
        vsync_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt_q <= '0;
      seen_q    <= 1'b0;
      active    <= 1'b0;
      kind      <= CS_UNDET;
      vsync     <= 1'b0;
      valid     <= 1'b0;
    end else begin
      win_cnt_q <= win_cnt_d;
      seen_q    <= seen_d;
      active    <= active_d;
      kind      <= kind_d;
      vsync     <= vsync_d;
      valid     <= valid_d;
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid); // R2
  AST_ACTIVE_AT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(active)); // R2
  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall_ev && (wide_ev || narrow_ev))); // R6
  AST_STALL_RAISES_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_ev && !flush) |=> (vsync && kind == CS_ORAND)); // R7
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!active && !vsync)); // R3
endmodule

// File: rtl/csync_type_detect.sv
module csync_type_detect
  import csd_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int WINDOW_TICKS = 80,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       csync_in,
  input  logic [1:0] cfg_shift,
  output logic       sync_active,
  output logic [1:0] sync_type,
  output logic       vsync_out,
  output logic       status_valid
);
  logic     rst_n_s;
  logic     sig_s;
  logic     edge_ev, wide_ev, narrow_ev, stall_ev, flush;
  cs_kind_t kind;

  csd_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_s)
  );

  csd_sync #(.STAGES(SYNC_STAGES)) u_in_sync (
    .clk(clk), .rst_n(rst_n_s), .d(csync_in), .q(sig_s)
  );

  csd_meas #(.CNT_W(CNT_W)) u_meas (
    .clk(clk), .rst_n(rst_n_s), .clr(flush), .sig(sig_s),
    .cfg_shift(cfg_shift), .edge_ev(edge_ev), .wide_ev(wide_ev),
    .narrow_ev(narrow_ev), .stall_ev(stall_ev)
  );

  csd_class #(.WINDOW_TICKS(WINDOW_TICKS)) u_class (
    .clk(clk), .rst_n(rst_n_s), .tick(tick_ms), .edge_ev(edge_ev),
    .wide_ev(wide_ev), .narrow_ev(narrow_ev), .stall_ev(stall_ev),
    .flush(flush), .active(sync_active), .kind(kind), .vsync(vsync_out),
    .valid(status_valid)
  );

  assign sync_type = sync_active ? kind : CS_NONE;
endmodule

// File: tb/csync_type_detect_bench.sv
`timescale 1ns/1ps
module csync_type_detect_bench;
  localparam int TD  = 10;
  localparam int WIN = 80;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_ms;
  logic       csync_in;
  logic [1:0] cfg_shift;
  logic       sync_active;
  logic [1:0] sync_type;
  logic       vsync_out;
  logic       status_valid;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int last_v = 0;
  int prev_v = 0;
  int nv = 0;

  csync_type_detect u_csync_type_detect (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .csync_in(csync_in),
    .cfg_shift(cfg_shift), .sync_active(sync_active), .sync_type(sync_type),
    .vsync_out(vsync_out), .status_valid(status_valid)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (status_valid) begin
      prev_v <= last_v;
      last_v <= cyc;
      nv     <= nv + 1;
    end
  end

  initial begin
    tick_ms = 1'b0;
    forever begin
      repeat (TD - 1) @(posedge clk);
      tick_ms <= 1'b1;
      @(posedge clk);
      tick_ms <= 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_type(input int style, input int p, input int hw, input int sh);
    int thr = p >> sh;
    if (hw > thr) return 2;
    if (style == 1) return 1;
    if (style == 2) return (p - hw > thr) ? 2 : 3;
    return 3;
  endfunction

  task automatic drive(input logic v, input int n);
    csync_in <= v;
    repeat (n) @(posedge clk);
  endtask

  // style 0: lines only, 1: level held during vertical interval, 2: inverted pulses
  task automatic frame(input int style, input int p, input int hw,
                       input bit do_chk, input int et, input int evs);
    for (int ln = 0; ln < 20; ln++) begin
      if (ln < 4 && style == 1) begin
        if (ln == 0) begin
          drive(1'b1, 3 * p + p / 2);
          if (do_chk) begin
            @(negedge clk);
            chk("R7 vsync during held interval", vsync_out, evs);
          end
          drive(1'b1, p - p / 2);
        end
      end else if (ln < 4 && style == 2) begin
        drive(1'b0, hw);
        drive(1'b1, p - hw);
        if (do_chk && ln == 3) begin
          @(negedge clk);
          chk("R7 vsync during inverted interval", vsync_out, evs);
        end
      end else begin
        if (do_chk && ln == 10) begin
          @(negedge clk);
          chk("R2 active while lines run", sync_active, 1);
          chk("R4 type code", sync_type, et);
          chk("R7 vsync low in active lines", vsync_out, 0);
        end
        drive(1'b1, hw);
        drive(1'b0, p - hw);
      end
    end
  endtask

  task automatic go_idle();
    drive(1'b0, 2 * WIN * TD + 400);
    @(negedge clk);
    chk("R3 active cleared when idle", sync_active, 0);
    chk("R3 type none when idle", sync_type, 0);
    chk("R3 vsync cleared when idle", vsync_out, 0);
  endtask

  task automatic pattern(input int style, input int p, input int hw, input int sh);
    int et = exp_type(style, p, hw, sh);
    int evs = (style != 0 && et != 3) ? 1 : 0;
    cfg_shift <= 2'(sh);
    repeat (3) frame(style, p, hw, 1'b0, et, evs);
    frame(style, p, hw, 1'b1, et, evs);
    go_idle();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n     = 1'b0;
    csync_in  = 1'b0;
    cfg_shift = 2'd2;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 active in reset", sync_active, 0);
    chk("R1 type in reset", sync_type, 0);
    chk("R1 vsync in reset", vsync_out, 0);
    chk("R1 strobe in reset", status_valid, 0);
    rst_n = 1'b1;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R1 outputs after release", {sync_active, sync_type, vsync_out}, 0);

    // R4: lines without vertical interval -> undetermined
    pattern(0, 40, 4, 2);
    // R6 R9: level held through vertical interval -> OR/AND
    pattern(1, 40, 4, 2);
    // R5: inverted pulses -> XOR
    pattern(2, 40, 4, 2);
    // R5: zero shift puts the threshold at a full period -> undetermined
    pattern(2, 40, 4, 0);

    // R8: switch style without going idle
    cfg_shift <= 2'd2;
    repeat (3) frame(1, 48, 4, 1'b0, 1, 1);
    frame(1, 48, 4, 1'b1, 1, 1);
    repeat (2) frame(2, 48, 4, 1'b0, 2, 1);
    frame(2, 48, 4, 1'b1, 2, 1);
    go_idle();

    // R2: strobe spacing equals one window
    chk("R2 strobe interval", last_v - prev_v, WIN * TD);
    chk("R2 strobes seen", (nv > 10) ? 1 : 0, 1);

    for (int i = 0; i < 6; i++) begin
      int p  = 32 + int'($urandom % 33);
      int hw = 2 + int'($urandom % 2);
      int sh = 1 + int'($urandom % 3);
      int st = 1 + int'($urandom % 2);
      pattern(st, p, hw, sh);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule